// File: doc/BRIEF.md
# SPI Peripheral Port with Clock Polarity Detection

This block is the device side of a four-wire serial link. It watches the link's serial clock, its active-low select and its controller-to-device data line from the system clock domain. It runs all three through two-flop synchronizers and finds the serial clock edges on the synchronized copy. It assembles incoming bits into parallel words and drives outgoing words bit by bit on the device-to-controller line.

No mode setting is needed. The block reads the idle level of the serial clock at the moment select becomes active. From that level it knows whether the controller runs with an idle-low clock (mode 0) or an idle-high clock (mode 3). In both modes it samples input on rising serial clock edges and changes output on falling edges. With an idle-high clock the first falling edge of a selection is a leading edge and does not advance the output.

Transmit words arrive on a one-cycle load strobe. A word loaded while the block is not selected is presented straight away, so its first bit is on the line when select asserts. A word loaded during a selection waits in a holding register until the current word ends. At each word boundary the block raises a received-word strobe and a transmit-request strobe together. The word length and the bit order are parameters. The system clock must run at least four times the serial clock rate.

Top module: `spi_peri_autopol`

## Requirements
- R1: After synchronous reset, `rx_valid_o`, `tx_req_o`, `miso_oe_o` and `miso_o` are 0 and `rx_word_o` is all zeros.
- R2: `miso_oe_o` is 1 exactly while the synchronized select is low. It follows a select change at the pin on the second system clock edge. `miso_o` is 0 whenever `miso_oe_o` is 0.
- R3: If the serial clock is high when select becomes active, the first falling edge of that selection leaves `miso_o` unchanged. If it is low, no edge is skipped.
- R4: `mosi_i` is sampled on every rising serial clock edge during a selection. After WORD_W samples, `rx_word_o` takes the assembled word and `rx_valid_o` pulses for one cycle, on the third system clock edge after the final rising edge at the pin. `rx_word_o` holds between pulses.
- R5: With LSB_FIRST=0, the first bit received lands in bit WORD_W-1 and the first bit sent is bit WORD_W-1 of the transmit word. With LSB_FIRST=1, bit 0 is first in both directions.
- R6: During a selection `miso_o` changes only on a counted falling edge, and each such edge moves to the next bit of the current word.
- R7: A word loaded with `tx_load_i` while not selected drives its first bit on `miso_o` as soon as select is seen.
- R8: `tx_req_o` pulses in the same cycle as `rx_valid_o`. A word loaded during a selection starts on the falling edge that follows the final rising edge of the current word.
- R9: If no word has been loaded since the last word boundary, the next word shifted out is all zeros.
- R10: Raising select in the middle of a word discards the partial word without a `rx_valid_o` pulse or a change to `rx_word_o`. The next selection starts counting from bit 0.
- R11: Raising select clears the word being transmitted, so a new selection without a load sends zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck_i | input | 1 | Serial clock from the controller |
| csn_i | input | 1 | Active-low select from the controller |
| mosi_i | input | 1 | Serial data from the controller |
| tx_word_i | input | WORD_W | Word to transmit |
| tx_load_i | input | 1 | One-cycle strobe that takes `tx_word_i` |
| miso_o | output | 1 | Serial data to the controller |
| miso_oe_o | output | 1 | Output enable for the data-to-controller line |
| rx_word_o | output | WORD_W | Last complete received word |
| rx_valid_o | output | 1 | One-cycle pulse when a new word is in `rx_word_o` |
| tx_req_o | output | 1 | One-cycle pulse at each word boundary asking for the next word |

## Verification
An idle-low transfer of two words is run with the second transmit word loaded in the middle of the first. It shows the start-up presentation of the first bit and the hand-over at the word boundary. An idle-high transfer of three words, with no load for the third, shows whether the leading falling edge is skipped and whether an empty holding register yields zeros. A selection dropped after three bits, followed by a full transfer with no load, separates a correct bit-count restart and transmit clear from a design that keeps stale state. A second instance with the opposite bit order runs on the same pins and is held against its own cycle model, so it shows any mix-up of bit order in either direction.

// File: rtl/spi_peri_pkg.sv
package spi_peri_pkg;

    // Number of flops each link pin passes through before use.
    localparam int unsigned SYNC_STAGES = 2;

    // Synchronized pin view with the edges found on it.
    typedef struct packed {
        logic sel;        // select active (synchronized level)
        logic sel_start;  // select just became active
        logic sel_end;    // select just became inactive
        logic sck_lvl;    // synchronized serial clock level
        logic sck_rise;
        logic sck_fall;
        logic mosi;
    } pin_evt_t;

    // What a falling serial clock edge does to the transmit side.
    typedef enum logic [1:0] {
        FALL_NONE  = 2'd0,
        FALL_SKIP  = 2'd1,   // leading edge of an idle-high selection
        FALL_LOAD  = 2'd2,   // word boundary: take the next word
        FALL_SHIFT = 2'd3    // move to the next bit
    } fall_act_e;

    function automatic fall_act_e classify_fall(input logic fall,
                                                input logic lead_pend,
                                                input logic boundary);
        if (!fall)     return FALL_NONE;
        if (lead_pend) return FALL_SKIP;
        if (boundary)  return FALL_LOAD;
        return FALL_SHIFT;
    endfunction

endpackage

// File: rtl/spi_peri_sync.sv
module spi_peri_sync
    import spi_peri_pkg::*;
#(
    parameter int unsigned STAGES = SYNC_STAGES
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     sck_i,
    input  logic     csn_i,
    input  logic     mosi_i,
    output pin_evt_t evt_o
);
    localparam int unsigned NLINES = 3;
    localparam int unsigned L_CSN  = 2;
    localparam int unsigned L_SCK  = 1;
    localparam int unsigned L_MOSI = 0;
    localparam logic [NLINES-1:0] IDLE = NLINES'(1) << L_CSN;

    logic [NLINES-1:0]             raw;
    logic [STAGES-1:0][NLINES-1:0] chain;
    logic [NLINES-1:0]             cur;
    logic [NLINES-1:0]             prev;

    assign raw = {csn_i, sck_i, mosi_i};
    assign cur = chain[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(STAGES); i++) chain[i] <= IDLE;
            prev <= IDLE;
        end else begin
            chain[0] <= raw;
            for (int i = 1; i < int'(STAGES); i++) chain[i] <= chain[i-1];
            prev <= cur;
        end
    end

    always_comb begin
        evt_o.sel       = ~cur[L_CSN];
        evt_o.sel_start = ~cur[L_CSN] &  prev[L_CSN];
        evt_o.sel_end   =  cur[L_CSN] & ~prev[L_CSN];
        evt_o.sck_lvl   =  cur[L_SCK];
        evt_o.sck_rise  =  cur[L_SCK] & ~prev[L_SCK];
        evt_o.sck_fall  = ~cur[L_SCK] &  prev[L_SCK];
        evt_o.mosi      =  cur[L_MOSI];
    end

endmodule

// File: rtl/spi_peri_rx.sv
module spi_peri_rx
    import spi_peri_pkg::*;
#(
    parameter int unsigned WORD_W    = 8,
    parameter bit          LSB_FIRST = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  pin_evt_t          evt_i,
    output logic [WORD_W-1:0] word_o,
    output logic              valid_o,
    output logic              last_rise_o
);
    localparam int unsigned       CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(WORD_W - 1);

    logic [CNT_W-1:0]  cnt;
    logic [WORD_W-1:0] sr;
    logic [WORD_W-1:0] sr_nxt;
    logic              active;
    logic              take;

    generate
        if (LSB_FIRST) begin : g_lsb
            assign sr_nxt = {evt_i.mosi, sr[WORD_W-1:1]};
        end else begin : g_msb
            assign sr_nxt = {sr[WORD_W-2:0], evt_i.mosi};
        end
    endgenerate

    assign active      = evt_i.sel & ~evt_i.sel_start;
    assign take        = active & evt_i.sck_rise;
    assign last_rise_o = take & (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            sr      <= '0;
            word_o  <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (!active) begin
                cnt <= '0;
            end else if (take) begin
                sr <= sr_nxt;
                if (cnt == LAST) begin
                    cnt     <= '0;
                    word_o  <= sr_nxt;
                    valid_o <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // R4: a complete word is flagged for a single cycle only
    p_valid_single_r4: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);

    // R4: the received word holds between strobes
    p_word_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !valid_o |-> $stable(word_o));

    // R10: dropping select restarts the bit count
    p_cnt_clear_r10: assert property (@(posedge clk) disable iff (rst)
        evt_i.sel_end |=> (cnt == '0));

endmodule

// File: rtl/spi_peri_tx.sv
module spi_peri_tx
    import spi_peri_pkg::*;
#(
    parameter int unsigned WORD_W    = 8,
    parameter bit          LSB_FIRST = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  pin_evt_t          evt_i,
    input  logic              last_rise_i,
    input  logic [WORD_W-1:0] tx_word_i,
    input  logic              tx_load_i,
    output logic              miso_o,
    output logic              miso_oe_o,
    output logic              tx_req_o
);
    logic [WORD_W-1:0] sr;
    logic [WORD_W-1:0] sr_shifted;
    logic [WORD_W-1:0] hold;
    logic              hold_full;
    logic              lead_pend;
    logic              boundary;
    logic              out_bit;
    logic              active;
    fall_act_e         act;

    generate
        if (LSB_FIRST) begin : g_lsb
            assign sr_shifted = {1'b0, sr[WORD_W-1:1]};
            assign out_bit    = sr[0];
        end else begin : g_msb
            assign sr_shifted = {sr[WORD_W-2:0], 1'b0};
            assign out_bit    = sr[WORD_W-1];
        end
    endgenerate

    assign active    = evt_i.sel & ~evt_i.sel_start;
    assign act       = active ? classify_fall(evt_i.sck_fall, lead_pend, boundary)
                              : FALL_NONE;
    assign miso_oe_o = evt_i.sel;
    assign miso_o    = evt_i.sel & out_bit;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr        <= '0;
            hold      <= '0;
            hold_full <= 1'b0;
            lead_pend <= 1'b0;
            boundary  <= 1'b0;
            tx_req_o  <= 1'b0;
        end else begin
            tx_req_o <= last_rise_i;
            if (!evt_i.sel) begin
                lead_pend <= 1'b0;
                boundary  <= 1'b0;
                hold_full <= 1'b0;
                if (tx_load_i)          sr <= tx_word_i;
                else if (evt_i.sel_end) sr <= '0;
            end else begin
                if (tx_load_i) begin
                    hold      <= tx_word_i;
                    hold_full <= 1'b1;
                end
                if (evt_i.sel_start) begin
                    lead_pend <= evt_i.sck_lvl;
                    boundary  <= 1'b0;
                end else begin
                    if (last_rise_i) boundary <= 1'b1;
                    case (act)
                        FALL_SKIP:  lead_pend <= 1'b0;
                        FALL_LOAD: begin
                            sr       <= hold_full ? hold : '0;
                            boundary <= 1'b0;
                            if (!tx_load_i) hold_full <= 1'b0;
                        end
                        FALL_SHIFT: sr <= sr_shifted;
                        default: ;
                    endcase
                end
            end
        end
    end

    // R6: while selected the outgoing word moves only on a falling edge
    p_sr_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        (evt_i.sel && !evt_i.sck_fall) |=> $stable(sr));

    // R3: the skip-leading-edge flag is armed only when select starts
    p_lead_at_start_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(lead_pend) |-> $past(evt_i.sel_start));

endmodule

// File: rtl/spi_peri_autopol.sv
module spi_peri_autopol
    import spi_peri_pkg::*;
#(
    parameter int unsigned WORD_W    = 8,
    parameter bit          LSB_FIRST = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sck_i,
    input  logic              csn_i,
    input  logic              mosi_i,
    input  logic [WORD_W-1:0] tx_word_i,
    input  logic              tx_load_i,
    output logic              miso_o,
    output logic              miso_oe_o,
    output logic [WORD_W-1:0] rx_word_o,
    output logic              rx_valid_o,
    output logic              tx_req_o
);
    pin_evt_t evt;
    logic     last_rise;

    spi_peri_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .sck_i  (sck_i),
        .csn_i  (csn_i),
        .mosi_i (mosi_i),
        .evt_o  (evt)
    );

    spi_peri_rx #(.WORD_W(WORD_W), .LSB_FIRST(LSB_FIRST)) u_rx (
        .clk         (clk),
        .rst         (rst),
        .evt_i       (evt),
        .word_o      (rx_word_o),
        .valid_o     (rx_valid_o),
        .last_rise_o (last_rise)
    );

    spi_peri_tx #(.WORD_W(WORD_W), .LSB_FIRST(LSB_FIRST)) u_tx (
        .clk         (clk),
        .rst         (rst),
        .evt_i       (evt),
        .last_rise_i (last_rise),
        .tx_word_i   (tx_word_i),
        .tx_load_i   (tx_load_i),
        .miso_o      (miso_o),
        .miso_oe_o   (miso_oe_o),
        .tx_req_o    (tx_req_o)
    );

    // R8: transmit request and received-word strobe coincide
    p_req_with_valid_r8: assert property (@(posedge clk) disable iff (rst)
        tx_req_o == rx_valid_o);

    // R2: the data line carries 0 while released
    p_miso_released_r2: assert property (@(posedge clk) disable iff (rst)
        !miso_oe_o |-> !miso_o);

endmodule

// File: tb/spi_peri_autopol_tb_top.sv
module spi_ref_model #(
    parameter int W   = 8,
    parameter bit LSB = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sck,
    input  logic         csn,
    input  logic         mosi,
    input  logic [W-1:0] tx_word,
    input  logic         tx_load,
    output logic [W-1:0] e_word,
    output logic         e_valid,
    output logic         e_req,
    output logic         e_oe,
    output logic         e_miso
);
    // pins as seen after the two-flop synchronizer, and one cycle earlier
    logic d1_c, d1_s, d1_m, d2_c, d2_s, d2_m, dp_c, dp_s;
    logic [W-1:0] cur, pend, acc;
    int   k, nbits;
    bit   pflag, brk, skip;

    always @(posedge clk) begin
        if (rst) begin
            d1_c = 1; d1_s = 0; d1_m = 0; d2_c = 1; d2_s = 0; d2_m = 0;
            dp_c = 1; dp_s = 0;
            cur = '0; pend = '0; acc = '0; k = 0; nbits = 0;
            pflag = 0; brk = 0; skip = 0;
            e_word = '0; e_valid = 0; e_req = 0;
        end else begin
            bit sel, start, fin, rise, fall;
            sel   = !d2_c;
            start = sel && dp_c;
            fin   = !sel && !dp_c;
            rise  = d2_s && !dp_s;
            fall  = !d2_s && dp_s;
            e_valid = 0;
            e_req   = 0;
            if (!sel) begin
                nbits = 0; pflag = 0; brk = 0; skip = 0;
                if (tx_load) begin cur = tx_word; k = 0; end
                else if (fin) begin cur = '0; k = 0; end
            end else if (start) begin
                skip = d2_s; nbits = 0; acc = '0; brk = 0;
                if (tx_load) begin pend = tx_word; pflag = 1; end
            end else begin
                if (rise) begin
                    if (LSB) acc[nbits] = d2_m;
                    else     acc = (acc << 1) | W'(d2_m);
                    nbits++;
                    if (nbits == W) begin
                        e_word = acc; e_valid = 1; e_req = 1;
                        nbits = 0; acc = '0; brk = 1;
                    end
                end
                if (fall) begin
                    if (skip) skip = 0;
                    else if (brk) begin
                        cur = pflag ? pend : '0; k = 0; pflag = 0; brk = 0;
                    end else k++;
                end
                if (tx_load) begin pend = tx_word; pflag = 1; end
            end
            dp_c = d2_c; dp_s = d2_s;
            d2_c = d1_c; d2_s = d1_s; d2_m = d1_m;
            d1_c = csn;  d1_s = sck;  d1_m = mosi;
        end
        e_oe   = !d2_c;
        e_miso = e_oe && (k < W) && (LSB ? cur[k] : cur[W-1-k]);
    end
endmodule

module spi_peri_autopol_tb_top;
    localparam int W    = 8;
    localparam int HALF = 4;   // system clocks per serial clock half period

    logic clk = 1'b0;
    logic rst, sck, csn, mosi, tx_load;
    logic [W-1:0] tx_word;
    always #2 clk = ~clk;      // 250 MHz

    logic         miso_m, oe_m, val_m, req_m, miso_l, oe_l, val_l, req_l;
    logic [W-1:0] word_m, word_l;
    logic         em_miso, em_oe, em_val, em_req, el_miso, el_oe, el_val, el_req;
    logic [W-1:0] em_word, el_word;

    spi_peri_autopol #(.WORD_W(W), .LSB_FIRST(1'b0)) dut_i (
        .clk(clk), .rst(rst), .sck_i(sck), .csn_i(csn), .mosi_i(mosi),
        .tx_word_i(tx_word), .tx_load_i(tx_load), .miso_o(miso_m),
        .miso_oe_o(oe_m), .rx_word_o(word_m), .rx_valid_o(val_m), .tx_req_o(req_m));

    spi_peri_autopol #(.WORD_W(W), .LSB_FIRST(1'b1)) dut_lsb_i (
        .clk(clk), .rst(rst), .sck_i(sck), .csn_i(csn), .mosi_i(mosi),
        .tx_word_i(tx_word), .tx_load_i(tx_load), .miso_o(miso_l),
        .miso_oe_o(oe_l), .rx_word_o(word_l), .rx_valid_o(val_l), .tx_req_o(req_l));

    spi_ref_model #(.W(W), .LSB(1'b0)) mdl_m (
        .clk(clk), .rst(rst), .sck(sck), .csn(csn), .mosi(mosi), .tx_word(tx_word),
        .tx_load(tx_load), .e_word(em_word), .e_valid(em_val), .e_req(em_req),
        .e_oe(em_oe), .e_miso(em_miso));

    spi_ref_model #(.W(W), .LSB(1'b1)) mdl_l (
        .clk(clk), .rst(rst), .sck(sck), .csn(csn), .mosi(mosi), .tx_word(tx_word),
        .tx_load(tx_load), .e_word(el_word), .e_valid(el_val), .e_req(el_req),
        .e_oe(el_oe), .e_miso(el_miso));

    int n_cmp = 0, n_bad = 0, nval = 0, nreq = 0, cyc = 0;
    bit cmp_en = 0, done = 0;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [W-1:0] rev(input logic [W-1:0] v);
        logic [W-1:0] r;
        for (int i = 0; i < W; i++) r[i] = v[W-1-i];
        return r;
    endfunction

    // cycle-by-cycle comparison against the reference models
    always @(negedge clk) begin
        if (cmp_en) begin
            chk("R4", "msb rx_valid", val_m, em_val);
            chk("R4", "msb rx_word", word_m, em_word);
            chk("R8", "msb tx_req", req_m, em_req);
            chk("R2", "msb miso_oe", oe_m, em_oe);
            chk("R6", "msb miso", miso_m, em_miso);
            chk("R5", "lsb rx_valid", val_l, el_val);
            chk("R5", "lsb rx_word", word_l, el_word);
            chk("R8", "lsb tx_req", req_l, el_req);
            chk("R2", "lsb miso_oe", oe_l, el_oe);
            chk("R5", "lsb miso", miso_l, el_miso);
            if (val_m) nval++;
            if (req_m) nreq++;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000 && !done) begin
            done = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic load(input logic [W-1:0] w);
        tx_word = w; tx_load = 1; wait_clk(1); tx_load = 0;
    endtask

    // controller side: cpol selects idle level; loads nxt[w] during word w if ld[w]
    task automatic xfer(input bit cpol, input int nw, input logic [0:3][W-1:0] mo,
                        input logic [0:3] ld, input logic [0:3][W-1:0] nxt,
                        output logic [0:3][W-1:0] gm, output logic [0:3][W-1:0] gl);
        gm = '0; gl = '0;
        sck = cpol; wait_clk(4);
        csn = 0; wait_clk(HALF);
        for (int w = 0; w < nw; w++) begin
            for (int b = 0; b < W; b++) begin
                if (b == 3 && ld[w]) load(nxt[w]);
                if (cpol) sck = 0;
                mosi = mo[w][W-1-b];
                wait_clk(HALF);
                gm[w] = {gm[w][W-2:0], miso_m};
                gl[w] = {gl[w][W-2:0], miso_l};
                sck = 1;
                wait_clk(HALF);
                if (!cpol) sck = 0;
            end
        end
        wait_clk(HALF);
        csn = 1;
        wait_clk(2 * HALF);
    endtask

    initial begin
        logic [0:3][W-1:0] gm, gl;
        int v0;
        rst = 1; csn = 1; sck = 0; mosi = 0; tx_load = 0; tx_word = '0;
        wait_clk(4);
        rst = 0;
        cmp_en = 1;
        wait_clk(1);
        chk("R1", "rx_valid after reset", val_m, 0);
        chk("R1", "tx_req after reset", req_m, 0);
        chk("R1", "rx_word after reset", word_m, 0);
        chk("R1", "miso_oe after reset", oe_m, 0);
        chk("R1", "miso after reset", miso_m, 0);

        // idle-low clock, second word loaded mid-way through the first
        load(8'hC6);
        xfer(0, 2, {8'h1E, 8'hB4, 8'h00, 8'h00}, 4'b1000,
             {8'h39, 8'h00, 8'h00, 8'h00}, gm, gl);
        chk("R7", "mode0 first word seen by controller", gm[0], 8'hC6);
        chk("R8", "mode0 reloaded word seen by controller", gm[1], 8'h39);
        chk("R5", "lsb-first words seen by controller", {gl[0], gl[1]},
            {rev(8'hC6), rev(8'h39)});
        chk("R4", "mode0 last received word", word_m, 8'hB4);
        chk("R5", "lsb-first received word", word_l, rev(8'hB4));
        chk("R4", "mode0 received-word strobes", nval, 2);
        chk("R8", "mode0 request strobes", nreq, 2);

        // idle-high clock, three words, third never loaded
        load(8'h93);
        xfer(1, 3, {8'h6D, 8'hF0, 8'h27, 8'h00}, 4'b1000,
             {8'h4B, 8'h00, 8'h00, 8'h00}, gm, gl);
        chk("R3", "mode3 first word after skipped leading edge", gm[0], 8'h93);
        chk("R8", "mode3 reloaded word", gm[1], 8'h4B);
        chk("R9", "mode3 unloaded word is zero", gm[2], 8'h00);
        chk("R3", "mode3 lsb-first first word", gl[0], rev(8'h93));
        chk("R4", "mode3 last received word", word_m, 8'h27);
        chk("R4", "total received-word strobes", nval, 5);

        // select dropped after three bits
        sck = 0; wait_clk(4);
        load(8'hFF);
        v0 = nval;
        csn = 0; wait_clk(HALF);
        chk("R2", "miso_oe while selected", oe_m, 1);
        for (int b = 0; b < 3; b++) begin
            mosi = 1; wait_clk(HALF); sck = 1; wait_clk(HALF); sck = 0;
        end
        wait_clk(HALF);
        csn = 1; wait_clk(2 * HALF);
        chk("R2", "miso_oe after deselect", oe_m, 0);
        chk("R10", "no strobe for partial word", nval, v0);
        chk("R10", "received word unchanged by partial word", word_m, 8'h27);
        xfer(0, 1, {8'h5C, 8'h00, 8'h00, 8'h00}, 4'b0000,
             {8'h00, 8'h00, 8'h00, 8'h00}, gm, gl);
        chk("R10", "fresh count after aborted word", word_m, 8'h5C);
        chk("R11", "transmit word cleared by deselect", gm[0], 8'h00);
        chk("R11", "lsb-first transmit word cleared", gl[0], 8'h00);

        wait_clk(4);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule